// File: doc/BRIEF.md
# Weighted Two-Level Channel Arbiter

This block decides which of several DMA channels may use a shared bus bandwidth budget during each arbitration slot. Every channel presents a request line, a one-bit priority level and a 4-bit weight. Exactly one channel at a time receives a one-hot grant. That grant stays in place until the holder pulses `done`, which closes the slot.

High-priority channels always beat low-priority ones. Inside the chosen level, each channel keeps a credit counter. A grant costs the winner one credit. When none of the requesting channels of that level has credit left, every channel of that level is refilled to its weight. Among the channels that still have credit, the winner is the first one found in cyclic order after the channel granted last. With steady requests, each channel therefore gets a share of slots that matches its weight. The block does not move data, does not signal any bus protocol and does not handle descriptors.

Top module: `wdrr_arbiter`

## Requirements
- R1: `grant` is always zero or one-hot, and `grant_valid` is high exactly when `grant` is non-zero.
- R2: A non-zero grant stays unchanged until a cycle in which `done` is high. A `done` pulse while `grant` is zero has no effect.
- R3: A slot opens at a clock edge where `grant` is zero or `done` is high. If no channel requests at that edge, `grant` becomes zero. If some channel requests, a new grant appears at that same edge, with no idle cycle.
- R4: The priority bit of channel k is `prio[k]`, where 1 means high. While any high-priority channel requests, only high-priority channels are granted.
- R5: Each grant decrements the winner's credit by one. When no requesting channel of the chosen level has non-zero credit at a slot opening, all channels of that level are reloaded to their effective weights, and the grant at that same edge is drawn from the reloaded credits.
- R6: The weight of channel k is `weight[4k+3:4k]`. A weight value of 0 behaves as 1.
- R7: The winner is the first channel of the chosen level that requests and has credit, searching upward from the index after the last granted channel and wrapping from NCH-1 to 0.
- R8: A channel that withdraws its request keeps its remaining credit until the next reload of its level.
- R9: Reset clears `grant` and all credits and sets the last-granted index to NCH-1, so the search starts at channel 0.
- R10: Take one level whose channels all request continuously, starting just after reset. Over a number of slots equal to the sum of the effective weights, each channel is granted exactly its effective weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Request line per channel |
| prio | input | NCH | Priority level per channel, 1 is high |
| weight | input | 4*NCH | Weight per channel, 4 bits each |
| done | input | 1 | Closes the current slot |
| grant | output | NCH | One-hot grant |
| grant_valid | output | 1 | A grant is present |

## Verification
Two functions can land in the same clock edge: the refill of a level's credits and the grant issued from those refilled credits. Both also coincide with `done`, which closes one slot and opens the next. The bench provokes this at the end of every weighted round. It sweeps many weight patterns, including zero weights, under continuous requests, so each round ends with a slot opening where every requester is empty. It then compares each grant with an arithmetic model that refills and then picks. A reload that was skipped, was applied a cycle late, or was charged twice shows up as a wrong channel or as wrong per-round counts.

// File: rtl/wdrr_pkg.sv
package wdrr_pkg;
  localparam int unsigned WGT_W = 4;
  typedef logic [WGT_W-1:0] wgt_t;

  // A zero weight is served as the smallest non-zero share.
  function automatic wgt_t eff_weight(input wgt_t w);
    return (w == '0) ? wgt_t'(1) : w;
  endfunction

  // Channel index reached by stepping off places past cur, wrapping at n.
  function automatic int wrap_idx(input int cur, input int off, input int n);
    return (cur + off) % n;
  endfunction
endpackage

// File: rtl/wdrr_credit_cell.sv
module wdrr_credit_cell
  import wdrr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  wgt_t wgt,
  input  logic view_load,
  input  logic commit_load,
  input  logic take,
  output wgt_t credit,
  output logic eff_nz
);
  wgt_t credit_q;
  wgt_t eff;

  // Credit as seen by this slot: refilled value when the level reloads.
  always_comb begin
    eff = view_load ? eff_weight(wgt) : credit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      credit_q <= '0;
    else if (take)
      credit_q <= eff - wgt_t'(1);
    else if (commit_load)
      credit_q <= eff;
  end

  assign eff_nz = (eff != '0);
  assign credit = credit_q;
endmodule

// File: rtl/wdrr_rr_pick.sv
module wdrr_rr_pick
  import wdrr_pkg::*;
#(
  parameter int unsigned NCH = 6,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  input  logic [IW-1:0]  last,
  output logic [NCH-1:0] pick,
  output logic [IW-1:0]  pick_idx
);
  always_comb begin
    pick     = '0;
    pick_idx = last;
    for (int off = 1; off <= int'(NCH); off++) begin
      int idx;
      idx = wrap_idx(int'(last), off, int'(NCH));
      if (pick == '0 && cand[idx]) begin
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/wdrr_arbiter.sv
module wdrr_arbiter
  import wdrr_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       req,
  input  logic [NCH-1:0]       prio,
  input  logic [NCH*WGT_W-1:0] weight,
  input  logic                 done,
  output logic [NCH-1:0]       grant,
  output logic                 grant_valid
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] grant_q;
  logic [IW-1:0]  last_q;

  // Named internal events, used by the bound checker.
  logic           slot_open;
  logic           issue;
  logic           use_hi;
  logic           reload_need;
  logic [NCH-1:0] elig_sel;
  logic [NCH-1:0] lvl_mask;
  logic [NCH-1:0] cred_nz;
  logic [NCH-1:0] eff_nz;
  logic [NCH-1:0] view_load;
  logic [NCH-1:0] cand;
  logic [NCH-1:0] pick;
  logic [IW-1:0]  pick_idx;
  wgt_t           credit [NCH];

  assign slot_open   = (grant_q == '0) || done;
  assign issue       = slot_open && (req != '0);
  assign use_hi      = ((req & prio) != '0);
  assign lvl_mask    = use_hi ? prio : ~prio;
  assign elig_sel    = req & lvl_mask;
  assign reload_need = (elig_sel != '0) && ((elig_sel & cred_nz) == '0);
  assign cand        = elig_sel & eff_nz;

  for (genvar k = 0; k < int'(NCH); k++) begin : g_cell
    assign view_load[k] = reload_need && lvl_mask[k];
    assign cred_nz[k]   = (credit[k] != '0);
    wdrr_credit_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .wgt         (weight[k*WGT_W +: WGT_W]),
      .view_load   (view_load[k]),
      .commit_load (view_load[k] && issue),
      .take        (pick[k] && issue),
      .credit      (credit[k]),
      .eff_nz      (eff_nz[k])
    );
  end

  wdrr_rr_pick #(.NCH(NCH)) u_pick (
    .cand     (cand),
    .last     (last_q),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(NCH - 1);
    end else if (slot_open) begin
      grant_q <= issue ? pick : '0;
      if (issue)
        last_q <= pick_idx;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = (grant_q != '0);
endmodule

// File: rtl/wdrr_arbiter_chk.sv
module wdrr_arbiter_chk #(
  parameter int unsigned NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] prio,
  input logic           done,
  input logic [NCH-1:0] grant,
  input logic           grant_valid
);
  logic open_now;
  assign open_now = (grant == '0) || done;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> (grant == $past(grant)));

  a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (open_now && req == '0) |=> (grant == '0));

  a_r3_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (open_now && req != '0) |=> ((grant & $past(req)) != '0));

  a_r4_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (open_now && (req & prio) != '0) |=> ((grant & $past(prio)) != '0));
endmodule

bind wdrr_arbiter wdrr_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .prio        (prio),
  .done        (done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/wdrr_arbiter_test.sv
`timescale 1ns/1ps
module wdrr_arbiter_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] prio = '0;
  logic [4*N-1:0] weight = '0;
  logic         done = 1'b0;
  logic [N-1:0] grant;
  logic         grant_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mcred [N];
  int mlast;

  always #10 clk = ~clk;

  wdrr_arbiter #(.NCH(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .weight(weight),
    .done(done), .grant(grant), .grant_valid(grant_valid)
  );

  function automatic int effw(int k);
    int w;
    w = int'(weight[k*4 +: 4]);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model of one slot opening: refill when the level is empty, then scan.
  task automatic mpick(output logic [N-1:0] g);
    logic hi;
    logic [N-1:0] el;
    bit empty;
    g = '0;
    hi = ((req & prio) != '0);
    for (int k = 0; k < N; k++) el[k] = req[k] && (prio[k] == hi);
    if (el == '0) return;
    empty = 1;
    for (int k = 0; k < N; k++) if (el[k] && mcred[k] > 0) empty = 0;
    if (empty)
      for (int k = 0; k < N; k++) if (prio[k] == hi) mcred[k] = effw(k);
    for (int s = 1; s <= N; s++) begin
      int k;
      k = (mlast + s) % N;
      if (g == '0 && el[k] && mcred[k] > 0) begin
        g[k] = 1'b1;
        mcred[k] = mcred[k] - 1;
        mlast = k;
      end
    end
  endtask

  task automatic expect_grant(input string tag);
    logic [N-1:0] e;
    mpick(e);
    check(int'(grant), int'(e), tag);
    check(int'(grant_valid), int'(e != '0), "R1 valid");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    done  = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < N; k++) mcred[k] = 0;
    mlast = N - 1;
    rst_n = 1'b1;
  endtask

  task automatic step();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] held;
    // R9: reset state
    do_reset();
    @(negedge clk);
    check(int'(grant), 0, "R9 reset grant");
    check(int'(grant_valid), 0, "R9 reset valid");

    // R2/R3: done with nobody requesting does nothing
    for (int i = 0; i < 3; i++) begin
      step();
      check(int'(grant), 0, "R2 idle done");
    end

    // R5 R6 R7 R10: sweep weight patterns, all low priority, all requesting
    for (int p = 0; p < 16; p++) begin
      int cnt [N];
      int total;
      for (int k = 0; k < N; k++) weight[k*4 +: 4] = 4'((p*7 + k*3) % 16);
      req = '1;
      prio = '0;
      total = 0;
      for (int k = 0; k < N; k++) begin
        cnt[k] = 0;
        total += effw(k);
      end
      do_reset();
      @(negedge clk);
      if (p == 0) check(int'(grant), 1, "R9 first grant ch0");
      expect_grant("R5 R7 sweep");
      for (int k = 0; k < N; k++) if (grant[k]) cnt[k]++;
      for (int s = 1; s < total; s++) begin
        step();
        expect_grant("R5 R6 R7 sweep");
        for (int k = 0; k < N; k++) if (grant[k]) cnt[k]++;
      end
      for (int k = 0; k < N; k++) check(cnt[k], effw(k), "R10 share per round");
      step();
      expect_grant("R5 reload with grant");
    end

    // R2: grant held while done is low, even as other requests change
    held = grant;
    for (int i = 0; i < 5; i++) begin
      req = held | 6'(i * 11);
      @(negedge clk);
      check(int'(grant), int'(held), "R2 hold");
    end
    req = '1;

    // R8: a dropped request keeps its credit
    for (int k = 0; k < N; k++) weight[k*4 +: 4] = 4'd3;
    do_reset();
    @(negedge clk);
    expect_grant("R8 start");
    for (int s = 0; s < 14; s++) begin
      if (s == 1) req[1] = 1'b0;
      if (s == 6) req[1] = 1'b1;
      step();
      expect_grant("R8 drop and return");
    end

    // R4: high priority channels take every slot
    prio = 6'b010100;
    for (int s = 0; s < 8; s++) begin
      step();
      expect_grant("R4 high only");
      check(int'((grant & prio) != '0), 1, "R4 level");
    end
    req = ~prio;
    for (int s = 0; s < 5; s++) begin
      step();
      expect_grant("R4 low after high leaves");
    end

    // R3: no requests clear the grant; a request from idle is served next edge
    req = '0;
    step();
    expect_grant("R3 clear");
    check(int'(grant), 0, "R3 clear zero");
    @(negedge clk);
    check(int'(grant), 0, "R3 stays idle");
    req = 6'b001000;
    @(negedge clk);
    expect_grant("R3 from idle");
    check(int'(grant), 8, "R3 from idle ch3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule